// File: doc/BRIEF.md
# Strobe-Latched Serial Register Interface

This block is the serial configuration port of a motor-driver control core. An external host drives three wires into it (a serial clock, a serial data input and an active-low strobe), and it drives one diagnostic data output back. The strobe stays high while the port is idle. The host pulls it low to open a transfer, clocks in one 16-bit word most significant bit first, and raises it again. The two leading bits of the word name one of four write registers: two configuration registers, a run register and a table-load register. The other fourteen bits become that register's new contents, and all four registers drive the control core as parallel outputs.

A word takes effect only when the strobe rises after exactly sixteen clocked bits. A frame of any other length is thrown away. Each register comes out of reset holding a non-zero default, so the core can run with no serial traffic at all. While a frame is open, a status word captured at the strobe's falling edge is shifted out on the data output, one bit per serial clock, in step with the incoming bits. All serial pins are brought into the system clock domain through synchronizers, so the system clock must run at four or more times the serial clock rate.

Top module: `strobe_serial_regs`

## Requirements
- R1: After reset the four register outputs hold their parameter defaults (configuration 0 = 14'h0C18, configuration 1 = 14'h0820, run = 14'h0940, table-load = 14'h0040), and `sdo_oe` and `sdo` are low.
- R2: A committed word selects its destination with bits 15:14: 2'b00 configuration 0, 2'b01 configuration 1, 2'b10 run, 2'b11 table-load.
- R3: Data is taken from `sdi` on each rising `sck` edge while the strobe is low, first bit into word bit 15. The destination register receives word bits 13:0.
- R4: A word is written only when `strn` rises after exactly 16 rising `sck` edges. After 15, 17 or any other count, no register changes.
- R5: `sck` edges that occur while `strn` is high shift in nothing and do not add to the bit count of the next frame.
- R6: When `strn` falls, the `status` input is captured. Its bit 15 appears on `sdo` first, and the next bit appears after each falling `sck` edge.
- R7: `sdo_oe` is high only while the synchronized strobe is low. `sdo` reads 0 whenever `sdo_oe` is low, and no write is committed while `sdo_oe` is high.
- R8: A commit changes at most one register, and the update lands within five system clocks of the strobe rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| strn | input | 1 | Active-low frame strobe |
| status | input | 16 | Diagnostic word captured at strobe fall |
| sdo | output | 1 | Serial diagnostic data out |
| sdo_oe | output | 1 | Drive enable for `sdo` (tri-state control) |
| cfg0 | output | 14 | Configuration register 0 contents |
| cfg1 | output | 14 | Configuration register 1 contents |
| run | output | 14 | Run register contents |
| tbl | output | 14 | Table-load register contents |

## Verification
The bench builds the block with its default parameters: 16-bit words, two synchronizer stages and the default register values. It drives the serial clock at one eighth of the system clock, so each half period spans four system cycles. That covers the two-stage synchronizer plus edge detection, and an exact sampling point can be computed for every `sdo` bit and every register update. With these settings, 15- and 17-bit frames, clock bursts while the strobe is high, and every address code all fall within a short run, and a behavioural queue model decides what each frame should commit.

// File: rtl/strobe_spi_pkg.sv
package strobe_spi_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int PAYLOAD_W = WORD_W - ADDR_W;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(WORD_W + 2);

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG0 = 2'b00,
        SEL_CFG1 = 2'b01,
        SEL_RUN  = 2'b10,
        SEL_TBL  = 2'b11
    } reg_sel_e;

    typedef logic [PAYLOAD_W-1:0] payload_t;

    typedef struct packed {
        reg_sel_e sel;
        payload_t payload;
    } frame_t;

    // Bit counter that sticks one past a full word so long frames stay invalid.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        if (c == CNT_W'(WORD_W + 1))
            return c;
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/strobe_spi_sync.sv
module strobe_spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/strobe_spi_frame.sv
module strobe_spi_frame
    import strobe_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              strn_s,
    input  logic [WORD_W-1:0] status,
    output logic              commit,
    output frame_t            word,
    output logic              sdo_bit,
    output logic              active,
    output logic              sck_fall,
    output logic              strb_fall
);

    logic              sck_d, strn_d;
    logic              sck_rise, strb_rise;
    logic [WORD_W-1:0] in_sh, out_sh;
    logic [CNT_W-1:0]  bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            strn_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            strn_d <= strn_s;
        end
    end

    assign active    = ~strn_s;
    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign strb_fall = strn_d & ~strn_s;
    assign strb_rise = ~strn_d & strn_s;

    // Receive path: count and shift only while the strobe is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            in_sh   <= '0;
            bit_cnt <= '0;
        end else if (strb_fall) begin
            bit_cnt <= '0;
        end else if (active && sck_rise) begin
            in_sh   <= {in_sh[WORD_W-2:0], sdi_s};
            bit_cnt <= sat_inc(bit_cnt);
        end
    end

    // Transmit path: load at strobe fall, advance on falling serial clock.
    always_ff @(posedge clk) begin
        if (rst)                        out_sh <= '0;
        else if (strb_fall)             out_sh <= status;
        else if (active && sck_fall)    out_sh <= {out_sh[WORD_W-2:0], 1'b0};
    end

    assign sdo_bit = out_sh[WORD_W-1];
    assign word    = frame_t'(in_sh);
    assign commit  = strb_rise && (bit_cnt == CNT_W'(WORD_W));

endmodule

// File: rtl/strobe_spi_regbank.sv
module strobe_spi_regbank
    import strobe_spi_pkg::*;
#(
    parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] DEFAULTS = '0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               commit,
    input  frame_t                             word,
    output logic [NUM_REGS-1:0][PAYLOAD_W-1:0] regs
);

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic hit;
            assign hit = commit && (word.sel == reg_sel_e'(r));
            always_ff @(posedge clk) begin
                if (rst)      regs[r] <= DEFAULTS[r];
                else if (hit) regs[r] <= word.payload;
            end
        end
    endgenerate

endmodule

// File: rtl/strobe_serial_regs.sv
module strobe_serial_regs
    import strobe_spi_pkg::*;
#(
    parameter int       SYNC_STAGES = 2,
    parameter payload_t DEF_CFG0    = 14'h0C18,
    parameter payload_t DEF_CFG1    = 14'h0820,
    parameter payload_t DEF_RUN     = 14'h0940,
    parameter payload_t DEF_TBL     = 14'h0040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              sdi,
    input  logic              strn,
    input  logic [WORD_W-1:0] status,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [PAYLOAD_W-1:0] cfg0,
    output logic [PAYLOAD_W-1:0] cfg1,
    output logic [PAYLOAD_W-1:0] run,
    output logic [PAYLOAD_W-1:0] tbl
);

    localparam logic [NUM_REGS-1:0][PAYLOAD_W-1:0] DEFAULTS =
        {DEF_TBL, DEF_RUN, DEF_CFG1, DEF_CFG0};

    logic [2:0] pins_s;
    logic       commit, sdo_bit, active, sck_fall, strb_fall;
    frame_t     word;
    logic [NUM_REGS-1:0][PAYLOAD_W-1:0] regs;

    strobe_spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({strn, sdi, sck}),
        .q  (pins_s)
    );

    strobe_spi_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (pins_s[0]),
        .sdi_s    (pins_s[1]),
        .strn_s   (pins_s[2]),
        .status   (status),
        .commit   (commit),
        .word     (word),
        .sdo_bit  (sdo_bit),
        .active   (active),
        .sck_fall (sck_fall),
        .strb_fall(strb_fall)
    );

    strobe_spi_regbank #(
        .DEFAULTS(DEFAULTS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .commit(commit),
        .word  (word),
        .regs  (regs)
    );

    assign sdo_oe = active;
    assign sdo    = active & sdo_bit;
    assign cfg0   = regs[SEL_CFG0];
    assign cfg1   = regs[SEL_CFG1];
    assign run    = regs[SEL_RUN];
    assign tbl    = regs[SEL_TBL];

endmodule

// File: rtl/strobe_serial_regs_chk.sv
module strobe_serial_regs_chk
    import strobe_spi_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sdo,
    input logic                 sdo_oe,
    input logic                 commit,
    input logic                 sck_fall,
    input logic                 strb_fall,
    input logic [PAYLOAD_W-1:0] cfg0,
    input logic [PAYLOAD_W-1:0] cfg1,
    input logic [PAYLOAD_W-1:0] run,
    input logic [PAYLOAD_W-1:0] tbl
);

    // R8: never more than one register moves in a cycle
    a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg0 != $past(cfg0), cfg1 != $past(cfg1),
                  run  != $past(run),  tbl  != $past(tbl)}));

    // R4: registers hold unless the frame unit commits
    a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(cfg0) && $stable(cfg1) && $stable(run) && $stable(tbl)));

    // R7: data output is quiet while not enabled
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

    // R7: commits happen only once the frame has closed
    a_r7_commit_after_close: assert property (@(posedge clk) disable iff (rst)
        commit |-> !sdo_oe);

    // R6: output bit moves only on a falling serial clock or a new frame
    a_r6_sdo_holds: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && !sck_fall && !strb_fall) |=> (!sdo_oe || $stable(sdo)));

endmodule

bind strobe_serial_regs strobe_serial_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .commit   (commit),
    .sck_fall (sck_fall),
    .strb_fall(strb_fall),
    .cfg0     (cfg0),
    .cfg1     (cfg1),
    .run      (run),
    .tbl      (tbl)
);

// File: tb/strobe_serial_regs_tb.sv
module strobe_serial_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        strn = 1'b1;
    logic [15:0] status = '0;
    logic        sdo, sdo_oe;
    logic [13:0] cfg0, cfg1, run, tbl;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [13:0] exp_r [4];
    bit          q [$];
    bit          cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_serial_regs u_dut (
        .clk(clk), .rst(rst), .sck(sck), .sdi(sdi), .strn(strn),
        .status(status), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg0(cfg0), .cfg1(cfg1), .run(run), .tbl(tbl)
    );

    function automatic logic [55:0] act_all();
        return {tbl, run, cfg1, cfg0};
    endfunction

    function automatic logic [55:0] exp_all();
        return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the queue model (R2/R3/R4/R8)
    always @(negedge clk) begin
        if (cmp_en && !rst)
            check("R8 per-cycle register compare", {8'h0, act_all()}, {8'h0, exp_all()});
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] st, input int nbits, input logic [31:0] bits);
        logic [15:0] w;
        @(negedge clk);
        status = st;
        strn   = 1'b0;
        q.delete();
        tick(HALF);
        check("R7 oe high in frame", {63'h0, sdo_oe}, 64'h1);
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[nbits-1-i];
            q.push_back(bits[nbits-1-i]);
            tick(HALF);
            if (i < 16) check("R6 sdo bit", {63'h0, sdo}, {63'h0, st[15-i]});
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        tick(HALF);
        cmp_en = 1'b0;
        strn   = 1'b1;
        tick(5);
        if (q.size() == 16) begin
            w = '0;
            foreach (q[k]) w = {w[14:0], q[k]};
            exp_r[w[15:14]] = w[13:0];
        end
        check("R7 oe low after frame", {62'h0, sdo_oe, sdo}, 64'h0);
        cmp_en = 1'b1;
    endtask

    task automatic regs_check(input string tag);
        check(tag, {8'h0, act_all()}, {8'h0, exp_all()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        exp_r[0] = 14'h0C18; exp_r[1] = 14'h0820;
        exp_r[2] = 14'h0940; exp_r[3] = 14'h0040;
        tick(4);
        rst = 1'b0;
        tick(2);
        regs_check("R1 reset defaults");
        check("R1 reset oe/sdo", {62'h0, sdo_oe, sdo}, 64'h0);
        cmp_en = 1'b1;

        // R2/R3: each address code
        frame(16'hA5C3, 16, {16'h0, 2'b00, 14'h1234});
        regs_check("R2 write cfg0");
        frame(16'h8001, 16, {16'h0, 2'b01, 14'h2ABC});
        regs_check("R2 write cfg1");
        frame(16'h5A3C, 16, {16'h0, 2'b10, 14'h3FFF});
        regs_check("R2 write run");
        frame(16'hFFFF, 16, {16'h0, 2'b11, 14'h0001});
        regs_check("R3 write tbl msb-first");
        check("R3 tbl payload", {50'h0, tbl}, 64'h0001);

        // R4: short and long frames are discarded
        frame(16'h1234, 15, {17'h0, 15'h7FFF});
        regs_check("R4 15-bit frame ignored");
        frame(16'h0F0F, 17, {15'h0, 17'h1_5555});
        regs_check("R4 17-bit frame ignored");
        check("R4 cfg1 unchanged", {50'h0, cfg1}, 64'h2ABC);

        // R5: clocks while strobe high count for nothing
        for (int i = 0; i < 8; i++) begin
            sdi = i[0];
            sck = 1'b1; tick(HALF);
            sck = 1'b0; tick(HALF);
        end
        regs_check("R5 idle clocks ignored");
        check("R5 oe idle", {62'h0, sdo_oe, sdo}, 64'h0);
        frame(16'h0000, 16, {16'h0, 2'b10, 14'h0155});
        check("R5 next frame exact", {50'h0, run}, 64'h0155);

        // R8: overwrite one register leaves the others alone
        frame(16'hC3A5, 16, {16'h0, 2'b00, 14'h2222});
        regs_check("R8 isolated update");

        tick(4);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule